// File: doc/BRIEF.md
# Framed Serial Sample Output Port

This block sends complex I/Q samples out of a one-bit serial line in fixed frames. A producer hands over a sample set, channel A I and Q and, in diversity mode, channel B I and Q as well. The set is held in holding registers while its frame is shifted out, most significant bit first. Each word is left justified in a selectable length of 16, 24 or 32 bits. The frame can end with one more word that carries register read-back data, or zero when nothing was read. That slot keeps the frame length fixed, so a read never changes the serial timing.

The port runs in one of two roles.
- **Bus master:** the block divides the system clock to make its own serial clock. It marks the first bit of each frame with a frame-sync pulse.
- **Cascaded:** the block follows an external serial clock. Its frame begins when a frame-start input is seen high on a falling edge. In a chain, that input is driven by the upstream device's frame-end output, so one device's slot follows the other's with no idle bit between them.

The sample input is a valid/ready stream with a single slot.
- `smp_ready` is high only while the holding registers are empty.
- A transfer happens on a clock where `smp_valid` and `smp_ready` are both high.
- The slot frees itself after the last bit of the frame.
- A producer must hold its sample until it sees ready. A valid seen while ready is low is not taken; instead it raises a sticky overrun flag and leaves the frame in progress as it was.

Top module: `ser_frame_tx`

## Requirements
- R1: The word-length code selects the bit count of every word in a frame: 00 gives 16, 01 gives 24 and 10 gives 32. Code 11 is not used.
- R2: Words go out MSB first and left justified. A 16-bit word carries the top 16 sample bits. A 24-bit or 32-bit word carries the top 23 sample bits, followed by zero padding to the word end.
- R3: With `cfg_diversity` low, a frame is A-I then A-Q. With it high, the frame is A-I, A-Q, B-I, B-Q.
- R4: One extra word ends the frame when `cfg_append` is high at frame start, or when a read is pending from a `rd_valid` pulse, whatever `cfg_append` is. The word is the top bits of the latched `rd_data`, MSB first, or all zero if no read is pending. A pending read is sent once only.
- R5: In master mode `sclk_out` has a half period of N system clocks, where N is 1 when `cfg_div` is 0 and `cfg_div` otherwise. `sdo` changes only together with a rising edge of `sclk_out`.
- R6: In master mode `fs_out` is high for exactly the serial period of the first bit of each frame.
- R7: `fe_out` rises on the serial rising edge that puts the last frame bit on `sdo`. It stays high for that bit only.
- R8: In cascade mode the bit timing follows `sclk_in`, `cfg_div` is ignored and `sclk_out` stays low. A frame starts on the first `sclk_in` rising edge after a falling edge that saw `fs_in` high.
- R9: `smp_ready` is low from the clock after a sample is accepted until the frame's last bit has been shifted out.
- R10: `smp_valid` while `smp_ready` is low sets `overrun`. Only reset clears `overrun`. The frame in progress is sent unchanged.
- R11: After reset `sdo`, `fs_out`, `fe_out`, `sclk_out` and `overrun` are low, and `smp_ready` is high.
- R12: Two successive bit shifts are always at least two system clocks apart, so frames are separated by zero or by two or more clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample set valid |
| smp_ready | output | 1 | Holding registers empty |
| smp_a_i | input | SAMPLE_W | Channel A in-phase sample |
| smp_a_q | input | SAMPLE_W | Channel A quadrature sample |
| smp_b_i | input | SAMPLE_W | Channel B in-phase sample |
| smp_b_q | input | SAMPLE_W | Channel B quadrature sample |
| cfg_master | input | 1 | 1 = bus master, 0 = cascaded |
| cfg_diversity | input | 1 | 1 = two-channel frames |
| cfg_wlen | input | 2 | Word-length code |
| cfg_div | input | DIV_W | Serial clock divider (master only) |
| cfg_append | input | 1 | Append read-back word |
| rd_valid | input | 1 | Read data strobe |
| rd_data | input | 32 | Read-back word |
| sclk_in | input | 1 | External serial clock (cascade) |
| fs_in | input | 1 | Frame start from upstream device |
| sclk_out | output | 1 | Generated serial clock (master) |
| sdo | output | 1 | Serial data |
| fs_out | output | 1 | Frame sync, first bit (master) |
| fe_out | output | 1 | Frame end, last bit |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The assertions check the following on every cycle:
- `sdo` and `fe_out` move only on serial rising ticks.
- Bit shifts stay at least two clocks apart.
- The held sample and its slot stay untouched while a frame runs.
- The overrun flag never drops.
- The bit counter stays inside the chosen word.

Only the bench scenarios can show that the bits on the line are the right ones: word order, padding zeros, the extra word and its one-shot read data, divider periods, and the gapless cascade handoff. The bench shows these by sweeping every word length, channel mode and append setting and rebuilding each frame from the requirements.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
  localparam int WORD_MAX = 32;
  localparam int HI_RES   = 23;
  localparam int NARROW   = 16;
  localparam int N_CH_WORDS = 4;
  localparam int N_SLOTS  = N_CH_WORDS + 1;
  localparam int BIDX_W   = $clog2(WORD_MAX + 1);
  localparam int WIDX_W   = $clog2(N_SLOTS + 1);

  typedef enum logic [1:0] {
    WLEN_16  = 2'b00,
    WLEN_24  = 2'b01,
    WLEN_32  = 2'b10,
    WLEN_BAD = 2'b11
  } wlen_e;

  function automatic logic [BIDX_W-1:0] word_bits(input logic [1:0] code);
    case (wlen_e'(code))
      WLEN_16: return BIDX_W'(16);
      WLEN_24: return BIDX_W'(24);
      default: return BIDX_W'(32);
    endcase
  endfunction
endpackage

// File: rtl/sfp_sclk_gen.sv
module sfp_sclk_gen #(
  parameter int DIV_W  = 4,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             master,
  input  logic [DIV_W-1:0] div,
  input  logic             sclk_in,
  input  logic             fs_in,
  output logic             rise_tick,
  output logic             fall_tick,
  output logic             fs_smp,
  output logic             sclk_q
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] half_m1;
  logic             expire;
  logic [SYNC_N:0]  ck_sh;
  logic [SYNC_N:0]  fs_sh;
  logic             ext_rise, ext_fall;

  assign half_m1 = (div == '0) ? '0 : div - DIV_W'(1);
  assign expire  = (cnt >= half_m1);

  always_ff @(posedge clk) begin
    if (!rst_n || !master) begin
      cnt    <= '0;
      sclk_q <= 1'b0;
    end else if (expire) begin
      cnt    <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ck_sh <= '0;
      fs_sh <= '0;
    end else begin
      ck_sh <= {ck_sh[SYNC_N-1:0], sclk_in};
      fs_sh <= {fs_sh[SYNC_N-1:0], fs_in};
    end
  end

  assign ext_rise  = ck_sh[SYNC_N-1] & ~ck_sh[SYNC_N];
  assign ext_fall  = ~ck_sh[SYNC_N-1] & ck_sh[SYNC_N];
  assign fs_smp    = fs_sh[SYNC_N-1];
  assign rise_tick = master ? (expire & ~sclk_q) : ext_rise;
  assign fall_tick = master ? (expire & sclk_q) : ext_fall;

  // R12
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_tick |=> !rise_tick);
endmodule

// File: rtl/sfp_hold.sv
module sfp_hold #(
  parameter int SAMPLE_W = 24,
  parameter int RD_W     = 32
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    smp_valid,
  output logic                                    smp_ready,
  input  logic [sfp_pkg::N_CH_WORDS-1:0][SAMPLE_W-1:0] smp_d,
  input  logic                                    release_i,
  output logic                                    full,
  output logic [sfp_pkg::N_CH_WORDS-1:0][SAMPLE_W-1:0] smp_q,
  output logic                                    overrun,
  input  logic                                    rd_valid,
  input  logic [RD_W-1:0]                         rd_data,
  input  logic                                    rd_take,
  output logic                                    rd_pend,
  output logic [RD_W-1:0]                         rd_word
);
  assign smp_ready = ~full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full  <= 1'b0;
      smp_q <= '0;
    end else if (smp_valid && !full) begin
      full  <= 1'b1;
      smp_q <= smp_d;
    end else if (release_i) begin
      full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                overrun <= 1'b0;
    else if (smp_valid && full) overrun <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_pend <= 1'b0;
      rd_word <= '0;
    end else if (rd_valid) begin
      rd_pend <= 1'b1;
      rd_word <= rd_data;
    end else if (rd_take) begin
      rd_pend <= 1'b0;
    end
  end

  // R10
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  // R10
  hold_intact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !release_i) |=> (full && $stable(smp_q)));
  // R9
  release_only_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    release_i |-> full);
endmodule

// File: rtl/sfp_shifter.sv
module sfp_shifter
  import sfp_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int RD_W     = 32
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  rise_tick,
  input  logic                                  fall_tick,
  input  logic                                  master,
  input  logic                                  fs_smp,
  input  logic [1:0]                            wlen,
  input  logic                                  diversity,
  input  logic                                  append,
  input  logic                                  hold_full,
  input  logic [N_CH_WORDS-1:0][SAMPLE_W-1:0]   smp_q,
  input  logic                                  rd_pend,
  input  logic [RD_W-1:0]                       rd_word,
  output logic                                  sdo,
  output logic                                  fs_out,
  output logic                                  fe_out,
  output logic                                  release_o,
  output logic                                  rd_take
);
  logic                  busy, go, wl16_q, div_q;
  logic [WIDX_W-1:0]     wsel, nw_q, nx_wsel, phys;
  logic [BIDX_W-1:0]     bidx, wb_q, nx_bidx;
  logic [WORD_MAX-1:0]   app_q;
  logic [WORD_MAX-1:0]   wvec [N_SLOTS];
  logic [WORD_MAX-1:0]   nx_word;
  logic                  at_wend, at_fend, nx_bit, nx_last, start_ok, app_now;

  function automatic logic [WORD_MAX-1:0] fmt(input logic [SAMPLE_W-1:0] s,
                                               input logic w16);
    logic [WORD_MAX-1:0] r;
    r = '0;
    if (w16) r[WORD_MAX-1 -: NARROW] = s[SAMPLE_W-1 -: NARROW];
    else     r[WORD_MAX-1 -: HI_RES] = s[SAMPLE_W-1 -: HI_RES];
    return r;
  endfunction

  for (genvar g = 0; g < N_CH_WORDS; g++) begin : g_fmt
    assign wvec[g] = fmt(smp_q[g], wl16_q);
  end
  assign wvec[N_CH_WORDS] = app_q;

  assign at_wend = (bidx == wb_q - BIDX_W'(1));
  assign at_fend = at_wend && (wsel == nw_q - WIDX_W'(1));
  assign nx_wsel = at_wend ? wsel + WIDX_W'(1) : wsel;
  assign nx_bidx = at_wend ? '0 : bidx + BIDX_W'(1);
  assign phys    = (!div_q && nx_wsel == WIDX_W'(2)) ? WIDX_W'(N_CH_WORDS) : nx_wsel;
  assign nx_word = wvec[phys];
  assign nx_bit  = nx_word[BIDX_W'(WORD_MAX - 1) - nx_bidx];
  assign nx_last = (nx_bidx == wb_q - BIDX_W'(1)) && (nx_wsel == nw_q - WIDX_W'(1));

  assign start_ok  = !busy && hold_full && (master || go);
  assign app_now   = append || rd_pend;
  assign release_o = rise_tick && busy && at_fend;
  assign rd_take   = rise_tick && start_ok && rd_pend;

  always_ff @(posedge clk) begin
    if (!rst_n)         go <= 1'b0;
    else if (fall_tick) go <= fs_smp && !master;
    else if (rise_tick) go <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      wsel   <= '0;
      bidx   <= '0;
      nw_q   <= WIDX_W'(2);
      wb_q   <= BIDX_W'(16);
      wl16_q <= 1'b1;
      div_q  <= 1'b0;
      app_q  <= '0;
      sdo    <= 1'b0;
      fs_out <= 1'b0;
      fe_out <= 1'b0;
    end else if (rise_tick) begin
      fs_out <= 1'b0;
      if (busy) begin
        if (at_fend) begin
          busy   <= 1'b0;
          sdo    <= 1'b0;
          fe_out <= 1'b0;
        end else begin
          wsel   <= nx_wsel;
          bidx   <= nx_bidx;
          sdo    <= nx_bit;
          fe_out <= nx_last;
        end
      end else if (start_ok) begin
        busy   <= 1'b1;
        wsel   <= '0;
        bidx   <= '0;
        wb_q   <= word_bits(wlen);
        wl16_q <= (wlen_e'(wlen) == WLEN_16);
        div_q  <= diversity;
        nw_q   <= (diversity ? WIDX_W'(4) : WIDX_W'(2)) + WIDX_W'(app_now);
        app_q  <= rd_pend ? WORD_MAX'(rd_word) : '0;
        sdo    <= smp_q[0][SAMPLE_W-1];
        fs_out <= master;
        fe_out <= 1'b0;
      end else begin
        fe_out <= 1'b0;
      end
    end
  end

  // R5
  sdo_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_tick |=> $stable(sdo));
  // R7
  fe_with_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fe_out) |-> $past(rise_tick));
  // R6
  fs_fe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fs_out && fe_out));
  // R1
  bit_in_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (bidx < wb_q));
  // R9
  busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> hold_full);
endmodule

// File: rtl/ser_frame_tx.sv
module ser_frame_tx
  import sfp_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int DIV_W    = 4,
  parameter int SYNC_N   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  output logic                smp_ready,
  input  logic [SAMPLE_W-1:0] smp_a_i,
  input  logic [SAMPLE_W-1:0] smp_a_q,
  input  logic [SAMPLE_W-1:0] smp_b_i,
  input  logic [SAMPLE_W-1:0] smp_b_q,
  input  logic                cfg_master,
  input  logic                cfg_diversity,
  input  logic [1:0]          cfg_wlen,
  input  logic [DIV_W-1:0]    cfg_div,
  input  logic                cfg_append,
  input  logic                rd_valid,
  input  logic [31:0]         rd_data,
  input  logic                sclk_in,
  input  logic                fs_in,
  output logic                sclk_out,
  output logic                sdo,
  output logic                fs_out,
  output logic                fe_out,
  output logic                overrun
);
  localparam int RD_W = WORD_MAX;

  logic rise_tick, fall_tick, fs_smp, sclk_q;
  logic full, release_w, rd_take, rd_pend;
  logic [RD_W-1:0] rd_word;
  logic [N_CH_WORDS-1:0][SAMPLE_W-1:0] smp_d, smp_q;

  assign smp_d    = {smp_b_q, smp_b_i, smp_a_q, smp_a_i};
  assign sclk_out = cfg_master & sclk_q;

  sfp_sclk_gen #(.DIV_W(DIV_W), .SYNC_N(SYNC_N)) u_clk (
    .clk(clk), .rst_n(rst_n), .master(cfg_master), .div(cfg_div),
    .sclk_in(sclk_in), .fs_in(fs_in), .rise_tick(rise_tick),
    .fall_tick(fall_tick), .fs_smp(fs_smp), .sclk_q(sclk_q)
  );

  sfp_hold #(.SAMPLE_W(SAMPLE_W), .RD_W(RD_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_d(smp_d), .release_i(release_w), .full(full), .smp_q(smp_q),
    .overrun(overrun), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_take(rd_take), .rd_pend(rd_pend), .rd_word(rd_word)
  );

  sfp_shifter #(.SAMPLE_W(SAMPLE_W), .RD_W(RD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .rise_tick(rise_tick), .fall_tick(fall_tick),
    .master(cfg_master), .fs_smp(fs_smp), .wlen(cfg_wlen),
    .diversity(cfg_diversity), .append(cfg_append), .hold_full(full),
    .smp_q(smp_q), .rd_pend(rd_pend), .rd_word(rd_word), .sdo(sdo),
    .fs_out(fs_out), .fe_out(fe_out), .release_o(release_w), .rd_take(rd_take)
  );

  // R9
  ready_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_ready) |=> !smp_ready);
endmodule

// File: tb/test_ser_frame_tx.sv
module test_ser_frame_tx;
  localparam int CLK_P = 10;
  localparam int HC    = 4;

  logic clk = 0, rst_n = 0;
  logic smp_valid = 0, smp_ready;
  logic [23:0] smp_a_i = 0, smp_a_q = 0, smp_b_i = 0, smp_b_q = 0;
  logic cfg_master = 1, cfg_diversity = 0, cfg_append = 0;
  logic [1:0] cfg_wlen = 0;
  logic [3:0] cfg_div = 0;
  logic rd_valid = 0;
  logic [31:0] rd_data = 0;
  logic sclk_in = 0, fs_in = 0;
  logic sclk_out, sdo, fs_out, fe_out, overrun;

  int n_chk = 0, n_fail = 0;
  logic exp_b [256];
  logic got_b [256];
  int exp_n, got_n, fe_err, fs_err, per_bad, misc_bad;

  always #(CLK_P/2) clk = ~clk;

  ser_frame_tx i_ser_frame_tx (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic [31:0] ew(input logic [23:0] s, input logic [1:0] wl);
    return (wl == 2'b00) ? {s[23:8], 16'h0} : {s[23:1], 9'h0};
  endfunction

  task automatic build_exp(input logic [1:0] wl, input logic dv, input logic ap,
                           input logic rp, input logic [31:0] rw);
    logic [31:0] w [5];
    int nw, wb;
    wb = (wl == 0) ? 16 : (wl == 1) ? 24 : 32;
    w[0] = ew(smp_a_i, wl); w[1] = ew(smp_a_q, wl);
    w[2] = ew(smp_b_i, wl); w[3] = ew(smp_b_q, wl);
    nw = dv ? 4 : 2;
    if (ap || rp) begin w[nw] = rp ? rw : 32'h0; nw++; end
    exp_n = 0;
    for (int k = 0; k < nw; k++)
      for (int b = 0; b < wb; b++) begin exp_b[exp_n] = w[k][31-b]; exp_n++; end
  endtask

  task automatic push(input int seed);
    smp_a_i = 24'hA5C3F1 ^ 24'(seed * 24'h13579B);
    smp_a_q = 24'h5A3C1F + 24'(seed * 24'h0F0F11);
    smp_b_i = 24'hC0FFEE ^ 24'(seed * 24'h2468AD);
    smp_b_q = 24'h3B9D27 - 24'(seed * 24'h111111);
    smp_valid = 1;
    @(negedge clk);
    smp_valid = 0;
  endtask

  task automatic read_pulse(input logic [31:0] v);
    rd_data = v; rd_valid = 1;
    @(negedge clk);
    rd_valid = 0;
  endtask

  task automatic cap_master(input int half);
    int to = 0, cnt = 0;
    logic prev;
    got_n = 0; fe_err = 0; fs_err = 0; per_bad = 0;
    prev = sclk_out;
    while (got_n == 0 && to < 20000) begin
      @(negedge clk); to++;
      if (prev && !sclk_out && fs_out) begin
        got_b[0] = sdo; got_n = 1;
        if (fe_out != (exp_n == 1)) fe_err++;
      end
      prev = sclk_out;
    end
    while (got_n < exp_n && to < 40000) begin
      @(negedge clk); to++; cnt++;
      if (prev && !sclk_out) begin
        if (cnt != 2 * half) per_bad++;
        cnt = 0;
        got_b[got_n] = sdo;
        if (fe_out != (got_n == exp_n - 1)) fe_err++;
        if (fs_out) fs_err++;
        got_n++;
      end
      prev = sclk_out;
    end
  endtask

  task automatic compare(input string req);
    int bad = 0, first = -1;
    check(got_n == exp_n, "R1", {req, " bit count"}, got_n, exp_n);
    for (int i = 0; i < exp_n; i++)
      if (got_b[i] !== exp_b[i]) begin bad++; if (first < 0) first = i; end
    check(bad == 0, req, "frame bits mismatch count / first index", bad, first);
    check(fe_err == 0, "R7", "fe_out position errors", fe_err, 0);
  endtask

  task automatic cascade_frame;
    misc_bad = 0; got_n = 0; fe_err = 0;
    sclk_in = 1; fs_in = 1;
    repeat (HC) @(negedge clk);
    sclk_in = 0;
    repeat (HC) @(negedge clk);
    sclk_in = 1; fs_in = 0;
    while (got_n < exp_n) begin
      repeat (HC) begin @(negedge clk); if (sclk_out) misc_bad++; end
      got_b[got_n] = sdo;
      if (fe_out != (got_n == exp_n - 1)) fe_err++;
      got_n++;
      sclk_in = 0;
      repeat (HC) @(negedge clk);
      sclk_in = 1;
    end
    repeat (HC) @(negedge clk);
    sclk_in = 0;
    repeat (HC) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R11 reset state
    check(!sdo && !fs_out && !fe_out && !sclk_out && !overrun, "R11", "outputs low in reset",
          {sdo, fs_out, fe_out, sclk_out, overrun}, 0);
    check(smp_ready === 1'b1, "R11", "ready in reset", smp_ready, 1);
    rst_n = 1;
    @(negedge clk);

    // R1 R2 R3 R4 R5 R6: sweep word length, channel mode, append, divider
    for (int idx = 0; idx < 12; idx++) begin
      logic [1:0] wl;
      logic dv, ap, rp;
      int dvs, half;
      logic [31:0] rw;
      wl = 2'(idx / 4); dv = idx[1]; ap = idx[0];
      dvs = (idx % 3 == 0) ? 0 : (idx % 3 == 1) ? 2 : 3;
      half = (dvs == 0) ? 1 : dvs;
      rp = (idx % 4 == 2);
      rw = 32'hDEAD_0000 + 32'(idx * 32'h1357);
      cfg_wlen = wl; cfg_diversity = dv; cfg_append = ap; cfg_div = 4'(dvs);
      @(negedge clk);
      if (rp) read_pulse(rw);
      push(idx);
      build_exp(wl, dv, ap, rp, rw);
      cap_master(half);
      compare(rp ? "R4" : "R2");
      check(per_bad == 0, "R5", "serial period errors", per_bad, 0);
      check(fs_err == 0, "R6", "fs_out beyond first bit", fs_err, 0);
      repeat (2 * half + 2) @(negedge clk);
      check(smp_ready === 1'b1, "R9", "ready after frame", smp_ready, 1);
    end

    // R4 read-forced word is sent once: next frame without append has no extra word
    cfg_wlen = 2'b01; cfg_diversity = 0; cfg_append = 0; cfg_div = 1;
    @(negedge clk);
    push(40);
    build_exp(2'b01, 0, 0, 0, 0);
    cap_master(1);
    compare("R4");
    repeat (6) @(negedge clk);

    // R10 overrun during a frame, frame unchanged; R9 ready low while busy
    cfg_wlen = 2'b10; cfg_diversity = 1; cfg_append = 0; cfg_div = 2;
    @(negedge clk);
    push(50);
    build_exp(2'b10, 1, 0, 0, 0);
    fork
      cap_master(2);
      begin
        logic [23:0] keep;
        repeat (60) @(negedge clk);
        check(smp_ready === 1'b0, "R9", "ready low mid-frame", smp_ready, 0);
        keep = smp_a_i;
        smp_a_i = ~keep; smp_valid = 1;
        @(negedge clk);
        smp_valid = 0; smp_a_i = keep;
        check(overrun === 1'b1, "R10", "overrun set", overrun, 1);
      end
    join
    compare("R10");
    repeat (8) @(negedge clk);
    check(overrun === 1'b1, "R10", "overrun sticky", overrun, 1);

    // R12 tight divider: bit period two clocks
    cfg_wlen = 2'b00; cfg_diversity = 0; cfg_div = 0;
    @(negedge clk);
    push(60);
    build_exp(2'b00, 0, 0, 0, 0);
    cap_master(1);
    compare("R12");
    check(per_bad == 0, "R12", "bit spacing two clocks", per_bad, 0);
    repeat (6) @(negedge clk);

    // R8 cascade: follows sclk_in, divider ignored, gapless start after fs_in
    cfg_master = 0; cfg_div = 5; cfg_wlen = 2'b01; cfg_diversity = 1; cfg_append = 1;
    repeat (4) @(negedge clk);
    push(70);
    build_exp(2'b01, 1, 1, 0, 0);
    cascade_frame;
    compare("R8");
    check(misc_bad == 0, "R8", "sclk_out high in cascade", misc_bad, 0);
    check(smp_ready === 1'b1, "R8", "ready after cascade frame", smp_ready, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule